// File: doc/BRIEF.md
# Sensor-Driven Main/Side Road Signal Controller

This block runs the signal heads at a crossing where a busy main road meets a rarely used side road. The main road shows green by default. It keeps green until a vehicle sensor on the side road reports a waiting car. The car must stay present for a qualifying time, and the main road must already have had its minimum green. The controller then steps the main road through yellow to red and gives the side road a fixed green. After that the side road goes yellow and then red, and the main road returns to green.

Every interval is counted in ticks of an external one-second strobe. One 4-bit counter, reloaded by the phase machine on each phase change, times all of them. The machine selects the counter's terminal value for each phase. Intervals longer than one counter span are built from several passes, which the machine counts. The side-road sensor enters through a two-stage synchronizer. The external active-low reset is asserted asynchronously and released synchronously inside the block.

Top module: `crossing_signal_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the main road shows green and the side road shows red. Each lamp output is one-hot with bit 0 = red, bit 1 = yellow and bit 2 = green.
- R2: With no side-road vehicle, the main road stays green for any length of time.
- R3: After entering green, the main road holds it for at least MAIN_MIN_S ticks (default 25), even if a side-road vehicle is already waiting.
- R4: The main road starts to yield only after the synchronized sensor has been high continuously for WAIT_S ticks (default 3). That wait is counted from the first tick after the machine enters its waiting phase, which happens once the minimum green has ended.
- R5: If the sensor drops during the qualifying wait, the wait is abandoned and the main road stays green. A later arrival must wait the full WAIT_S ticks again.
- R6: The main road goes green, then yellow, then red. The side road turns from red to green in the same cycle that the main road turns red.
- R7: Every yellow phase, on either road, lasts exactly YEL_S ticks (default 4).
- R8: Side-road green lasts exactly SIDE_MAX_S ticks (default 25), even if the sensor stays high. The side road then shows yellow, and it turns red in the same cycle that the main road returns to green.
- R9: In every cycle at least one road shows red, and each lamp output has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_1s | input | 1 | One-cycle timing strobe, one per second |
| side_sensor | input | 1 | Side-road vehicle present (asynchronous) |
| main_lamp | output | 3 | Main-road lamps, {green, yellow, red} |
| side_lamp | output | 3 | Side-road lamps, {green, yellow, red} |

## Verification
The assertions assume that the timing strobe is high for no more than one cycle at a time. They also assume that the sensor changes slowly compared with the clock, so the two-stage synchronizer resolves cleanly. The stimulus produces a one-cycle tick every ten clocks and changes the sensor only on the falling clock edge just after a tick. This keeps every sensor change a few cycles away from the next tick, so each expected interval is an exact count of ticks.

// File: rtl/xsig_pkg.sv
package xsig_pkg;

  typedef logic [2:0] lamp_t;

  localparam lamp_t LAMP_RED = 3'b001;
  localparam lamp_t LAMP_YEL = 3'b010;
  localparam lamp_t LAMP_GRN = 3'b100;

  typedef enum logic [2:0] {
    PH_MAIN_MIN  = 3'd0,
    PH_MAIN_IDLE = 3'd1,
    PH_MAIN_WAIT = 3'd2,
    PH_MAIN_YEL  = 3'd3,
    PH_SIDE_GRN  = 3'd4,
    PH_SIDE_YEL  = 3'd5
  } phase_e;

  // number of counter passes needed to cover an interval
  function automatic int unsigned passes_for(input int unsigned secs, input int unsigned span);
    return (secs + span - 1) / span;
  endfunction

  // length of the last (possibly partial) pass
  function automatic int unsigned last_len(input int unsigned secs, input int unsigned span);
    return secs - span * (passes_for(secs, span) - 1);
  endfunction

endpackage

// File: rtl/xsig_sync2.sv
module xsig_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xsig_interval_timer.sv
module xsig_interval_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                 cnt_d = '0;
    else if (cnt_q == term_i)   cnt_d = '0;
    else                        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = tick_i & (cnt_q == term_i);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_i); // R7
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> !tick_i); // R4
endmodule

// File: rtl/xsig_phase_fsm.sv
module xsig_phase_fsm
  import xsig_pkg::*;
#(
  parameter int unsigned MAIN_MIN_S = 25,
  parameter int unsigned SIDE_MAX_S = 25,
  parameter int unsigned YEL_S      = 4,
  parameter int unsigned WAIT_S     = 3,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned PASS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sensor_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] term_o,
  output lamp_t            main_lamp_o,
  output lamp_t            side_lamp_o
);
  localparam int unsigned SPAN = 1 << CNT_W;

  localparam logic [PASS_W-1:0] MIN_NP  = PASS_W'(passes_for(MAIN_MIN_S, SPAN));
  localparam logic [PASS_W-1:0] SIDE_NP = PASS_W'(passes_for(SIDE_MAX_S, SPAN));
  localparam logic [PASS_W-1:0] YEL_NP  = PASS_W'(passes_for(YEL_S, SPAN));
  localparam logic [PASS_W-1:0] WAIT_NP = PASS_W'(passes_for(WAIT_S, SPAN));

  localparam logic [CNT_W-1:0] MIN_LM1  = CNT_W'(last_len(MAIN_MIN_S, SPAN) - 1);
  localparam logic [CNT_W-1:0] SIDE_LM1 = CNT_W'(last_len(SIDE_MAX_S, SPAN) - 1);
  localparam logic [CNT_W-1:0] YEL_LM1  = CNT_W'(last_len(YEL_S, SPAN) - 1);
  localparam logic [CNT_W-1:0] WAIT_LM1 = CNT_W'(last_len(WAIT_S, SPAN) - 1);

  phase_e            state_q, state_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic [PASS_W-1:0] np;
  logic [CNT_W-1:0]  lm1;
  logic              final_pass, expire;

  // per-phase interval shape
  always_comb begin
    np  = PASS_W'(1);
    lm1 = '1;
    case (state_q)
      PH_MAIN_MIN:  begin np = MIN_NP;  lm1 = MIN_LM1;  end
      PH_MAIN_WAIT: begin np = WAIT_NP; lm1 = WAIT_LM1; end
      PH_MAIN_YEL,
      PH_SIDE_YEL:  begin np = YEL_NP;  lm1 = YEL_LM1;  end
      PH_SIDE_GRN:  begin np = SIDE_NP; lm1 = SIDE_LM1; end
      default:      begin np = PASS_W'(1); lm1 = '1;    end
    endcase
  end

  assign final_pass = (pass_q == (np - PASS_W'(1)));
  assign term_o     = final_pass ? lm1 : '1;
  assign expire     = done_i & final_pass;

  // next-state: Mealy on the synchronized sensor
  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_MAIN_MIN:  if (expire) state_d = sensor_i ? PH_MAIN_WAIT : PH_MAIN_IDLE;
      PH_MAIN_IDLE: if (sensor_i) state_d = PH_MAIN_WAIT;
      PH_MAIN_WAIT: begin
        if (!sensor_i)   state_d = PH_MAIN_IDLE;
        else if (expire) state_d = PH_MAIN_YEL;
      end
      PH_MAIN_YEL:  if (expire) state_d = PH_SIDE_GRN;
      PH_SIDE_GRN:  if (expire) state_d = PH_SIDE_YEL;
      PH_SIDE_YEL:  if (expire) state_d = PH_MAIN_MIN;
      default:      state_d = PH_MAIN_MIN;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_comb begin
    pass_d = pass_q;
    if (load_o)                    pass_d = '0;
    else if (done_i && !final_pass) pass_d = pass_q + PASS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_MAIN_MIN;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
    end
  end

  // lamp decode
  always_comb begin
    main_lamp_o = LAMP_GRN;
    side_lamp_o = LAMP_RED;
    case (state_q)
      PH_MAIN_YEL: begin main_lamp_o = LAMP_YEL; side_lamp_o = LAMP_RED; end
      PH_SIDE_GRN: begin main_lamp_o = LAMP_RED; side_lamp_o = LAMP_GRN; end
      PH_SIDE_YEL: begin main_lamp_o = LAMP_RED; side_lamp_o = LAMP_YEL; end
      default:     begin main_lamp_o = LAMP_GRN; side_lamp_o = LAMP_RED; end
    endcase
  end

  AST_WAIT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_MAIN_WAIT && !sensor_i) |=> (state_q == PH_MAIN_IDLE)); // R5
  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q < np); // R3
endmodule

// File: rtl/crossing_signal_ctrl.sv
module crossing_signal_ctrl
  import xsig_pkg::*;
#(
  parameter int unsigned MAIN_MIN_S = 25,
  parameter int unsigned SIDE_MAX_S = 25,
  parameter int unsigned YEL_S      = 4,
  parameter int unsigned WAIT_S     = 3,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned PASS_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1s,
  input  logic       side_sensor,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             sensor_s;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_term;
  lamp_t            main_l, side_l;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  xsig_sync2 #(.STAGES(2)) u_sensor_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (side_sensor),
    .q_o   (sensor_s)
  );

  xsig_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick_1s),
    .load_i (tmr_load),
    .term_i (tmr_term),
    .done_o (tmr_done)
  );

  xsig_phase_fsm #(
    .MAIN_MIN_S (MAIN_MIN_S),
    .SIDE_MAX_S (SIDE_MAX_S),
    .YEL_S      (YEL_S),
    .WAIT_S     (WAIT_S),
    .CNT_W      (CNT_W),
    .PASS_W     (PASS_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sensor_i    (sensor_s),
    .done_i      (tmr_done),
    .load_o      (tmr_load),
    .term_o      (tmr_term),
    .main_lamp_o (main_l),
    .side_lamp_o (side_l)
  );

  assign main_lamp = main_l;
  assign side_lamp = side_l;

  AST_LAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (main_lamp == LAMP_RED) || (side_lamp == LAMP_RED)); // R9
  AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($countones(main_lamp) == 1) && ($countones(side_lamp) == 1)); // R9
  AST_MAIN_YEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (main_lamp == LAMP_YEL && $past(main_lamp) != LAMP_YEL) |-> ($past(main_lamp) == LAMP_GRN)); // R6
  AST_SIDE_GRN_ENTRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (side_lamp == LAMP_GRN && $past(side_lamp) != LAMP_GRN) |-> ($past(main_lamp) == LAMP_YEL)); // R6
  AST_MAIN_GRN_RETURN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (main_lamp == LAMP_GRN && $past(main_lamp) == LAMP_RED) |-> ($past(side_lamp) == LAMP_YEL)); // R8
endmodule

// File: tb/sim_crossing_signal_ctrl.sv
module sim_crossing_signal_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [2:0] RED = 3'b001;
  localparam logic [2:0] YEL = 3'b010;
  localparam logic [2:0] GRN = 3'b100;
  localparam int MIN_S = 25, SIDE_S = 25, YEL_T = 4, WAIT_T = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       sensor = 1'b0;
  logic [2:0] main_lamp, side_lamp;

  int n_chk = 0, n_err = 0;
  int n_ticks = 0;
  int m_mark = 0, s_mark = 0;
  logic [2:0] pm = GRN, ps = RED;
  int mg_dur = 0, my_dur = 0, sg_dur = 0, sy_dur = 0;
  int mg_end_at = 0, mg_ends = 0, sy_ends = 0;
  int viol = 0, yr_bad = 0, rg_bad = 0;

  always #2 clk = ~clk;

  crossing_signal_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1s     (tick),
    .side_sensor (sensor),
    .main_lamp   (main_lamp),
    .side_lamp   (side_lamp)
  );

  // one-cycle tick every ten clocks
  initial begin
    forever begin
      repeat (9) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      n_ticks++;
    end
  end

  // lamp monitor: phase lengths measured in consumed ticks
  always @(posedge clk) begin
    int cons;
    #1;
    cons = n_ticks + (tick ? 1 : 0);
    if (!rst_n) begin
      m_mark = cons; s_mark = cons; pm = main_lamp; ps = side_lamp;
    end else begin
      if (!(main_lamp == RED || side_lamp == RED)) viol++;
      if ($countones(main_lamp) != 1 || $countones(side_lamp) != 1) viol++;
      if (main_lamp != pm) begin
        if (pm == GRN) begin mg_dur = cons - m_mark; mg_end_at = cons; mg_ends++; end
        if (pm == YEL) begin
          my_dur = cons - m_mark;
          if (!(main_lamp == RED && side_lamp == GRN && ps == RED)) yr_bad++;
        end
        if (pm == RED && !(main_lamp == GRN && side_lamp == RED && ps == YEL)) rg_bad++;
        if (pm == GRN && main_lamp != YEL) yr_bad++;
        m_mark = cons; pm = main_lamp;
      end
      if (side_lamp != ps) begin
        if (ps == GRN) sg_dur = cons - s_mark;
        if (ps == YEL) begin sy_dur = cons - s_mark; sy_ends++; end
        s_mark = cons; ps = side_lamp;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait for the next tick edge; t returns the ticks consumed so far
  task automatic after_tick(output int t);
    @(posedge clk);
    while (!tick) @(posedge clk);
    #1;
    t = n_ticks + 1;
    @(negedge clk);
  endtask

  task automatic skip_ticks(input int n);
    int t;
    for (int i = 0; i < n; i++) after_tick(t);
  endtask

  task automatic t_reset(input logic sens);
    int t;
    rst_n = 1'b0;
    sensor = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 main green in reset", main_lamp, GRN);
    chk("R1 side red in reset", side_lamp, RED);
    after_tick(t);
    rst_n = 1'b1;
    sensor = sens;
    repeat (3) @(negedge clk);
    chk("R1 main green after release", main_lamp, GRN);
    chk("R1 side red after release", side_lamp, RED);
  endtask

  task automatic t_idle;
    int e0;
    e0 = mg_ends;
    skip_ticks(60);
    chk("R2 main still green without vehicle", main_lamp, GRN);
    chk("R2 no yield without vehicle", mg_ends, e0);
  endtask

  task automatic t_early_full_cycle;
    t_reset(1'b1);
    wait (mg_ends == 1);
    chk("R3 R4 main green = min + wait", mg_dur, MIN_S + WAIT_T);
    wait (sy_ends == 1);
    @(negedge clk);
    chk("R7 main yellow length", my_dur, YEL_T);
    chk("R6 side green as main turns red", yr_bad, 0);
    chk("R8 side green length with sensor held", sg_dur, SIDE_S);
    chk("R7 side yellow length", sy_dur, YEL_T);
    chk("R8 main green returns as side turns red", rg_bad, 0);
    chk("R8 main lamp after side yellow", main_lamp, GRN);
    wait (mg_ends == 2);
    chk("R3 second main green honours minimum", mg_dur, MIN_S + WAIT_T);
    wait (sy_ends == 2);
    @(negedge clk);
  endtask

  task automatic t_late_arrival;
    int t;
    int e0;
    sensor = 1'b0;
    skip_ticks(40);
    chk("R2 main green after minimum, no vehicle", main_lamp, GRN);
    e0 = mg_ends;
    after_tick(t);
    sensor = 1'b1;
    wait (mg_ends == e0 + 1);
    chk("R4 yield after qualifying wait", mg_end_at, t + WAIT_T);
    wait (sy_ends == e0 + 1);
    @(negedge clk);
    sensor = 1'b0;
  endtask

  task automatic t_cancel;
    int t;
    int t2;
    int e0;
    sensor = 1'b0;
    skip_ticks(40);
    e0 = mg_ends;
    after_tick(t);
    sensor = 1'b1;
    skip_ticks(1);
    sensor = 1'b0;
    skip_ticks(9);
    chk("R5 main stays green after sensor drop", main_lamp, GRN);
    chk("R5 no yield after cancelled wait", mg_ends, e0);
    after_tick(t2);
    sensor = 1'b1;
    wait (mg_ends == e0 + 1);
    chk("R5 new arrival waits full period", mg_end_at, t2 + WAIT_T);
  endtask

  task automatic t_reset_mid_side;
    wait (side_lamp == GRN);
    skip_ticks(5);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset forces main green", main_lamp, GRN);
    chk("R1 async reset forces side red", side_lamp, RED);
    sensor = 1'b0;
    t_reset(1'b0);
    skip_ticks(30);
    chk("R2 main green after mid-phase reset", main_lamp, GRN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset(1'b0);
    t_idle;
    t_early_full_cycle;
    t_late_arrival;
    t_cancel;
    t_reset_mid_side;
    chk("R9 lamp exclusion and one-hot every cycle", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule